// File: doc/BRIEF.md
# Audio Link Reset and Wake Sequencer

This block sits on the controller side of a serial audio codec link and drives the link's active-low codec reset line and its frame sync line. Software asks for a cold reset or a warm reset through two request pins. A cold reset holds the codec reset line low for a timed minimum, which puts every codec register back to its power-on value. A warm reset leaves the codec registers alone and only wakes the link. It does this by raising sync for a timed minimum while the codec's bit clock is stopped.

After either pulse the block releases its outputs and waits a bounded time for the codec to start toggling the bit clock. The bit clock is brought into the system clock domain and watched for edges. A restart ends the sequence with a one-cycle done pulse. If no edge arrives in time, a sticky error flag is set instead. While the link is quiet, a rising level on the codec's data-in line counts as a wake request from the codec. It sets a sticky status flag, and that flag drives an interrupt only when the interrupt enable is set. All pins are plain level control and status signals. There is no streamed data.

Top module: `aclink_rst_seq`

## Requirements
- R1: A cold request accepted in idle drives `link_rst_n` low for exactly PULSE_CYC = CYC_PER_US*PULSE_US system cycles, starting the cycle after the request is sampled; `sync` stays low.
- R2: A warm request accepted while the bit clock is idle drives `sync` high for exactly PULSE_CYC cycles, and `link_rst_n` stays high throughout.
- R3: Once a pulse ends, its output has returned to the inactive level before the block starts waiting for the bit clock. The first bit clock edge seen after that gives exactly one `done` pulse, and `busy` drops in the same cycle.
- R4: If no bit clock edge is seen within TIMEOUT_CYC cycles after a pulse ends, `timeout_err` is set. `busy` is then high for exactly PULSE_CYC+TIMEOUT_CYC cycles and no `done` pulse is given.
- R5: A warm request made while the bit clock is running (an edge within the last IDLE_CYC cycles) is ignored: `sync` and `busy` stay low, and `warm_ignored` is set.
- R6: When cold and warm requests arrive in the same cycle, the cold reset is performed and the warm request is dropped.
- R7: `busy` is high from the cycle after an accepted request until completion or timeout. Requests made while busy have no effect on `link_rst_n` or `sync`.
- R8: A rising edge on `sdin` while the sequencer is idle and the bit clock is idle sets `wake_sts`. A rising edge while the bit clock is running does not. `irq` is high exactly when `wake_sts` and `wake_ie` are both high.
- R9: A one-cycle `sts_clr` clears `timeout_err`, `warm_ignored` and `wake_sts`.
- R10: After reset: `link_rst_n` high; `sync`, `busy`, `done`, `timeout_err`, `warm_ignored`, `wake_sts` and `irq` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cold_req | input | 1 | Cold reset request, sampled each cycle |
| warm_req | input | 1 | Warm reset request, sampled each cycle |
| wake_ie | input | 1 | Wake interrupt enable |
| sts_clr | input | 1 | Clears the sticky status flags |
| bit_clk | input | 1 | Codec bit clock, asynchronous |
| sdin | input | 1 | Codec serial data-in, used for wake detection, asynchronous |
| link_rst_n | output | 1 | Active-low codec reset |
| sync | output | 1 | Link sync line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on bit clock restart |
| timeout_err | output | 1 | Sticky: bit clock did not restart in time |
| warm_ignored | output | 1 | Sticky: warm request refused because the bit clock was running |
| wake_sts | output | 1 | Sticky: codec wake seen |
| irq | output | 1 | Wake interrupt |

## Verification
A table of request patterns covers six cases: cold alone, warm alone, cold and warm together, each reset with and without a codec clock restart, and a warm request while the clock is running. For each case the bench counts the cycles of reset-low, sync-high and busy, and records done, timeout and refusal. From these it can tell the cold path from the warm path, a completed sequence from a timed-out one, and an accepted warm request from a refused one. Directed tests then issue requests in the middle of a pulse. They also raise wake edges with the interrupt masked, with it unmasked, and with the bit clock running, and clear the status flags.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COLD = 2'd1,
    ST_WARM = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_t;
endpackage

// File: rtl/aclink_sync_edge.sv
module aclink_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic any_edge,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign lvl      = sh[STAGES-1];
  assign any_edge = sh[STAGES] ^ sh[STAGES-1];
  assign rise     = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/aclink_activity.sv
module aclink_activity #(
  parameter int IDLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic running
);
  localparam int W = $clog2(IDLE_CYC + 1);
  localparam logic [W-1:0] SAT = W'(IDLE_CYC);

  logic [W-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            quiet <= SAT;
    else if (edge_i)       quiet <= '0;
    else if (quiet != SAT) quiet <= quiet + 1'b1;
  end

  assign running = (quiet != SAT);

  // an observed edge marks the clock as running on the next cycle (R5)
  assert_edge_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> running);
endmodule

// File: rtl/aclink_timer.sv
module aclink_timer #(
  parameter int MAXV = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic [$clog2(MAXV+1)-1:0]  limit,
  output logic                       hit
);
  localparam int W = $clog2(MAXV + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!hit)    cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit);
endmodule

// File: rtl/aclink_rst_seq.sv
module aclink_rst_seq
  import aclink_pkg::*;
#(
  parameter int CYC_PER_US  = 125,
  parameter int PULSE_US    = 1,
  parameter int TIMEOUT_CYC = 256,
  parameter int IDLE_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cold_req,
  input  logic warm_req,
  input  logic wake_ie,
  input  logic sts_clr,
  input  logic bit_clk,
  input  logic sdin,
  output logic link_rst_n,
  output logic sync,
  output logic busy,
  output logic done,
  output logic timeout_err,
  output logic warm_ignored,
  output logic wake_sts,
  output logic irq
);
  localparam int PULSE_CYC = CYC_PER_US * PULSE_US;
  localparam int TMAX      = (PULSE_CYC > TIMEOUT_CYC) ? PULSE_CYC : TIMEOUT_CYC;
  localparam int TW        = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PULSE_LIM = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] TMO_LIM   = TW'(TIMEOUT_CYC - 1);

  seq_state_t state, nxt;
  logic bclk_lvl, bclk_edge, bclk_rise;
  logic sd_lvl, sd_edge, sd_rise;
  logic clk_running, tmr_hit, tmr_restart;
  logic [TW-1:0] tmr_limit;

  aclink_sync_edge #(.STAGES(SYNC_STAGES)) u_bclk_sync (
    .clk(clk), .rst_n(rst_n), .din(bit_clk),
    .lvl(bclk_lvl), .any_edge(bclk_edge), .rise(bclk_rise));

  aclink_sync_edge #(.STAGES(SYNC_STAGES)) u_sdin_sync (
    .clk(clk), .rst_n(rst_n), .din(sdin),
    .lvl(sd_lvl), .any_edge(sd_edge), .rise(sd_rise));

  aclink_activity #(.IDLE_CYC(IDLE_CYC)) u_act (
    .clk(clk), .rst_n(rst_n), .edge_i(bclk_edge), .running(clk_running));

  aclink_timer #(.MAXV(TMAX)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
    .limit(tmr_limit), .hit(tmr_hit));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (cold_req)                     nxt = ST_COLD;
        else if (warm_req && !clk_running) nxt = ST_WARM;
      end
      ST_COLD, ST_WARM: if (tmr_hit) nxt = ST_WAIT;
      ST_WAIT: if (bclk_edge || tmr_hit) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign tmr_restart = (nxt != state);
  assign tmr_limit   = (state == ST_WAIT) ? TMO_LIM : PULSE_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      done         <= 1'b0;
      timeout_err  <= 1'b0;
      warm_ignored <= 1'b0;
      wake_sts     <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_WAIT) && bclk_edge;
      if (sts_clr) begin
        timeout_err  <= 1'b0;
        warm_ignored <= 1'b0;
        wake_sts     <= 1'b0;
      end else begin
        if (state == ST_WAIT && !bclk_edge && tmr_hit)
          timeout_err <= 1'b1;
        if (state == ST_IDLE && !cold_req && warm_req && clk_running)
          warm_ignored <= 1'b1;
        if (state == ST_IDLE && !clk_running && sd_rise)
          wake_sts <= 1'b1;
      end
    end
  end

  assign link_rst_n = (state != ST_COLD);
  assign sync       = (state == ST_WARM);
  assign busy       = (state != ST_IDLE);
  assign irq        = wake_sts & wake_ie;

  // warm pulse only while the bit clock is quiet
  assert_sync_clk_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !clk_running);

  // a pulse begins only from the idle sequencer
  assert_start_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync) || $fell(link_rst_n)) |-> !$past(busy));

  // done follows a sequence with both outputs released
  assert_done_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && link_rst_n && !sync));

  // timeout flag rises only as the sequence ends
  assert_tmo_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(timeout_err) && !$past(sts_clr)) |-> (!busy && !done));

  // interrupt masked by enable
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_ie |-> !irq);

  // clear wins over status
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr |=> (!timeout_err && !warm_ignored && !wake_sts));
endmodule

// File: tb/aclink_rst_seq_bench.sv
module aclink_rst_seq_bench;
  localparam int CPU  = 4;
  localparam int PUS  = 1;
  localparam int PLS  = CPU * PUS;
  localparam int TMO  = 40;
  localparam int IDLE = 16;

  typedef struct packed {
    logic       cold;
    logic       warm;
    logic       clk_on;
    logic       restart;
    logic [7:0] rst_lo;
    logic [7:0] sync_hi;
    logic [7:0] busy_len;   // 8'hFF = not checked
    logic [7:0] dones;
    logic       tmo;
    logic       ign;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'(PLS), 8'd0, 8'hFF, 8'd1, 1'b0, 1'b0},        // R1 cold, restart
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 8'(PLS), 8'hFF, 8'd1, 1'b0, 1'b0},        // R2 warm, restart
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'(PLS), 8'd0, 8'hFF, 8'd1, 1'b0, 1'b0},        // R6 both
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'(PLS), 8'd0, 8'(PLS+TMO), 8'd0, 1'b1, 1'b0},  // R4 cold timeout
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 8'(PLS), 8'(PLS+TMO), 8'd0, 1'b1, 1'b0},  // R4 warm timeout
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 1'b1}             // R5 warm refused
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cold_req = 1'b0, warm_req = 1'b0, wake_ie = 1'b0, sts_clr = 1'b0;
  logic bit_clk = 1'b0, sdin = 1'b0, bclk_en = 1'b0;
  logic link_rst_n, sync, busy, done, timeout_err, warm_ignored, wake_sts, irq;

  int n_chk = 0, n_fail = 0;
  int c_rst, c_sync, c_busy, c_done;
  logic sync_at_done;

  aclink_rst_seq #(.CYC_PER_US(CPU), .PULSE_US(PUS), .TIMEOUT_CYC(TMO),
                   .IDLE_CYC(IDLE), .SYNC_STAGES(2)) u_aclink_rst_seq (
    .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .warm_req(warm_req),
    .wake_ie(wake_ie), .sts_clr(sts_clr), .bit_clk(bit_clk), .sdin(sdin),
    .link_rst_n(link_rst_n), .sync(sync), .busy(busy), .done(done),
    .timeout_err(timeout_err), .warm_ignored(warm_ignored),
    .wake_sts(wake_sts), .irq(irq));

  always #4 clk = ~clk;

  initial begin
    forever begin
      #12;
      if (bclk_en) bit_clk = ~bit_clk;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_sts();
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    @(negedge clk);
  endtask

  // monitor n cycles; optionally start the bit clock once the outputs are released
  task automatic observe(input int n, input logic restart);
    c_rst = 0; c_sync = 0; c_busy = 0; c_done = 0; sync_at_done = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (!link_rst_n) c_rst++;
      if (sync) c_sync++;
      if (busy) c_busy++;
      if (done) begin c_done++; sync_at_done = sync_at_done | sync; end
      if (restart && !bclk_en && busy && link_rst_n && !sync) bclk_en = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R10 reset state
    check("R10 link_rst_n", int'(link_rst_n), 1);
    check("R10 sync", int'(sync), 0);
    check("R10 busy", int'(busy), 0);
    check("R10 flags", int'({done, timeout_err, warm_ignored, wake_sts, irq}), 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // table-driven main function
    foreach (VEC[k]) begin
      bclk_en = VEC[k].clk_on;
      wait_cyc(IDLE + 6);
      cold_req = VEC[k].cold;
      warm_req = VEC[k].warm;
      @(negedge clk);
      cold_req = 1'b0;
      warm_req = 1'b0;
      observe(100, VEC[k].restart);
      check($sformatf("R1 rst_lo vec%0d", k), c_rst, int'(VEC[k].rst_lo));
      check($sformatf("R2 sync_hi vec%0d", k), c_sync, int'(VEC[k].sync_hi));
      if (VEC[k].busy_len != 8'hFF)
        check($sformatf("R4 busy_len vec%0d", k), c_busy, int'(VEC[k].busy_len));
      check($sformatf("R3 done vec%0d", k), c_done, int'(VEC[k].dones));
      check($sformatf("R3 sync low at done vec%0d", k), int'(sync_at_done), 0);
      check($sformatf("R4 timeout vec%0d", k), int'(timeout_err), int'(VEC[k].tmo));
      check($sformatf("R5 ignored vec%0d", k), int'(warm_ignored), int'(VEC[k].ign));
      clear_sts();
      check($sformatf("R9 cleared vec%0d", k), int'({timeout_err, warm_ignored}), 0);
      bclk_en = 1'b0;
    end

    // R7: requests during a pulse have no effect
    wait_cyc(IDLE + 6);
    cold_req = 1'b1;
    @(negedge clk);
    cold_req = 1'b0;
    warm_req = 1'b1;
    wait_cyc(2);
    cold_req = 1'b1;
    @(negedge clk);
    cold_req = 1'b0;
    warm_req = 1'b0;
    observe(100, 1'b0);
    check("R7 rst low unaffected", c_rst, PLS - 3);
    check("R7 no sync while busy", c_sync, 0);
    check("R7 busy length", c_busy, PLS + TMO - 3);
    clear_sts();

    // R8 wake masked
    wait_cyc(IDLE + 6);
    wake_ie = 1'b0;
    sdin = 1'b1;
    wait_cyc(6);
    check("R8 wake_sts set", int'(wake_sts), 1);
    check("R8 irq masked", int'(irq), 0);
    wake_ie = 1'b1;
    @(negedge clk);
    check("R8 irq enabled", int'(irq), 1);
    sdin = 1'b0;
    clear_sts();
    check("R9 wake cleared", int'(wake_sts), 0);
    check("R9 irq cleared", int'(irq), 0);

    // R8 no wake while the bit clock runs
    bclk_en = 1'b1;
    wait_cyc(10);
    sdin = 1'b1;
    wait_cyc(6);
    check("R8 no wake with clock running", int'(wake_sts), 0);
    check("R8 no irq with clock running", int'(irq), 0);
    sdin = 1'b0;
    bclk_en = 1'b0;
    wait_cyc(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule